// File: doc/BRIEF.md
# Rotate-Mask-ALU-Shift-Merge Field Datapath

This block is the single-cycle data path of a small bit-field processor. In every accepted cycle it takes a source value from one of eight working registers or from the external bus read data. It rotates that value to the right, with bits leaving the bottom re-entering at the top. A bus source is then cut down to a field of the selected length. The value passes through an ALU whose second operand is always working register 0, which acts as the auxiliary register.

The ALU result goes one of two ways. If the destination is a register, the full result is written to it. If the destination is the bus, the result is shifted up to the field position and merged into the bus latch. The latch holds the destination's prior contents when the source is a register. It holds the source data when source and destination are on the same bus bank. When they sit on opposite banks, the whole byte is driven and every bit outside the field is zero.

A one-bit overflow flag keeps the carry-out of the most recent addition. Field length is encoded as length minus one, so a code of 7 selects a full-width field, which disables masking, shifting and merging. Instruction decode and bus timing are outside this block.

Top module: `fld_datapath`

## Requirements
- R1: While rst_ni is low, all working registers, ovf_o, bus_wr_o and bus_wr_data_o are zero.
- R2: For a register source, the operand is the register rotated right end-around by rot_amt_i bits, and fld_len_i does not mask it.
- R3: For a bus source, the operand is bus_rd_data_i rotated right by rot_amt_i and then ANDed with a mask of the low L bits, where L = fld_len_i + 1 (1 to 8).
- R4: alu_op_i selects the ALU result from the operand and working register 0: 2'b00 passes the operand, 2'b01 adds modulo 256, 2'b10 ANDs, and 2'b11 XORs.
- R5: An accepted ADD loads ovf_o with the carry-out of the 8-bit sum on the next clock edge; any other op, or an idle cycle, leaves ovf_o unchanged.
- R6: A register destination (dst_is_bus_i = 0) receives the full ALU result at the clock edge, and bus_wr_o is 0 in the following cycle.
- R7: For a bus destination with a register source, bus_wr_o is 1 in the cycle after the op, and bus_wr_bank_o equals dst_bank_i. Inside the field (bits pos to pos+L-1, clipped at bit 7), bus_wr_data_o holds the ALU result shifted left by fld_pos_i. Every bit outside the field holds bus_rd_data_i, which is the destination's prior contents.
- R8: For a bus source and bus destination with equal bank bits, bus_rd_data_i is both the ALU source and the merge background: bits outside the field hold the source data.
- R9: For a bus source and bus destination with different bank bits, all 8 bits are written: the field carries the shifted result and every other bit is 0.
- R10: When fld_len_i = 7 and the destination is the bus, fld_pos_i is ignored and bus_wr_data_o is the unshifted ALU result.
- R11: With op_valid_i low, no register or ovf_o changes and bus_wr_o is 0 in the next cycle.
- R12: peek_data_o shows, without delay, the working register selected by peek_sel_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_valid_i | input | 1 | Execute an operation this cycle |
| src_is_bus_i | input | 1 | Source is bus read data (1) or a working register (0) |
| src_sel_i | input | 3 | Source working register index |
| src_bank_i | input | 1 | Bank of the bus source |
| dst_is_bus_i | input | 1 | Destination is the bus (1) or a working register (0) |
| dst_sel_i | input | 3 | Destination working register index |
| dst_bank_i | input | 1 | Bank of the bus destination |
| alu_op_i | input | 2 | 00 move, 01 add, 10 and, 11 xor |
| rot_amt_i | input | 3 | Right-rotate amount |
| fld_len_i | input | 3 | Field length minus one |
| fld_pos_i | input | 3 | Bit position of the field's LSB at the destination |
| bus_rd_data_i | input | 8 | Bus data: the source, or the destination's prior contents |
| bus_wr_o | output | 1 | Bus write strobe, one cycle after the op |
| bus_wr_data_o | output | 8 | Merged bus write data |
| bus_wr_bank_o | output | 1 | Bank of the bus write |
| ovf_o | output | 1 | Carry-out of the most recent ADD |
| peek_sel_i | input | 3 | Register observation select |
| peek_data_o | output | 8 | Selected working register contents |

## Verification
The bench targets these corner cases:

- Rotation by nonzero amounts from both source kinds. A design that rotated left, or shifted instead of rotating, would lose or misplace the wrapped bits.
- A register source with a narrow length code. A design that masked register sources would clear high operand bits.
- Fields at the top of the byte that clip, and full-width fields with a nonzero position. A design that shifted a full-width result would corrupt the low bits.
- The same bus data on equal and on opposite banks. A design with the bank rule wrong would either keep stray source bits or zero the merge background.
- An ADD with carry followed by non-add ops and by idle cycles. A design that cleared or recomputed the flag on every op would report the wrong overflow.

// File: rtl/fld_dp_pkg.sv
package fld_dp_pkg;
  typedef enum logic [1:0] {
    ALU_MOVE = 2'b00,
    ALU_ADD  = 2'b01,
    ALU_AND  = 2'b10,
    ALU_XOR  = 2'b11
  } alu_op_e;
endpackage

// File: rtl/fld_rotmask.sv
module fld_rotmask #(
  parameter int DW = 8,
  parameter int SW = $clog2(DW)
) (
  input  logic [DW-1:0] data_i,
  input  logic [SW-1:0] rot_i,
  input  logic [SW-1:0] len_i,
  input  logic          mask_en_i,
  output logic [DW-1:0] data_o
);
  localparam int LW = SW + 1;

  logic [2*DW-1:0] dbl;
  logic [DW-1:0]   rot_data;
  logic [DW-1:0]   low_mask;
  logic [LW-1:0]   len_p1;

  assign len_p1   = LW'(len_i) + LW'(1);
  assign dbl      = {data_i, data_i} >> rot_i;
  assign rot_data = dbl[DW-1:0];
  assign low_mask = ~({DW{1'b1}} << len_p1);
  assign data_o   = mask_en_i ? (rot_data & low_mask) : rot_data;
endmodule

// File: rtl/fld_alu.sv
module fld_alu
  import fld_dp_pkg::*;
#(
  parameter int DW = 8
) (
  input  alu_op_e       op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] aux_i,
  output logic [DW-1:0] res_o,
  output logic          carry_o
);
  logic [DW:0] sum;
  assign sum = {1'b0, a_i} + {1'b0, aux_i};

  always_comb begin
    carry_o = 1'b0;
    unique case (op_i)
      ALU_MOVE: res_o = a_i;
      ALU_ADD: begin
        res_o   = sum[DW-1:0];
        carry_o = sum[DW];
      end
      ALU_AND:  res_o = a_i & aux_i;
      ALU_XOR:  res_o = a_i ^ aux_i;
      default:  res_o = a_i;
    endcase
  end
endmodule

// File: rtl/fld_merge.sv
module fld_merge #(
  parameter int DW = 8,
  parameter int SW = $clog2(DW)
) (
  input  logic [DW-1:0] res_i,
  input  logic [DW-1:0] latch_i,
  input  logic [SW-1:0] len_i,
  input  logic [SW-1:0] pos_i,
  input  logic          opposite_i,
  output logic [DW-1:0] fld_mask_o,
  output logic [DW-1:0] data_o
);
  localparam int IW = SW + 2;

  logic          full;
  logic [IW-1:0] lo, hi;
  logic [DW-1:0] part_mask;
  logic [DW-1:0] shifted;

  assign full = &len_i;
  assign lo   = IW'(pos_i);
  assign hi   = IW'(pos_i) + IW'(len_i) + IW'(1);

  for (genvar i = 0; i < DW; i++) begin : g_bit
    assign part_mask[i] = (IW'(i) >= lo) && (IW'(i) < hi);
  end

  assign fld_mask_o = full ? {DW{1'b1}} : part_mask;
  assign shifted    = full ? res_i : (res_i << pos_i);
  assign data_o     = opposite_i ? (shifted & fld_mask_o)
                                 : ((latch_i & ~fld_mask_o) | (shifted & fld_mask_o));
endmodule

// File: rtl/fld_regfile.sv
module fld_regfile #(
  parameter int DW    = 8,
  parameter int NREGS = 8,
  parameter int AW    = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o,
  output logic [DW-1:0] aux_o,
  input  logic [AW-1:0] peek_addr_i,
  output logic [DW-1:0] peek_data_o
);
  logic [DW-1:0] regs_q [NREGS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREGS; i++) regs_q[i] <= '0;
    end else if (we_i) begin
      regs_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o     = regs_q[raddr_i];
  assign aux_o       = regs_q[0];
  assign peek_data_o = regs_q[peek_addr_i];

  assert_reg_write_lands_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/fld_datapath.sv
module fld_datapath
  import fld_dp_pkg::*;
#(
  parameter int DW    = 8,
  parameter int NREGS = 8,
  parameter int AW    = $clog2(NREGS),
  parameter int SW    = $clog2(DW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_valid_i,
  input  logic          src_is_bus_i,
  input  logic [AW-1:0] src_sel_i,
  input  logic          src_bank_i,
  input  logic          dst_is_bus_i,
  input  logic [AW-1:0] dst_sel_i,
  input  logic          dst_bank_i,
  input  logic [1:0]    alu_op_i,
  input  logic [SW-1:0] rot_amt_i,
  input  logic [SW-1:0] fld_len_i,
  input  logic [SW-1:0] fld_pos_i,
  input  logic [DW-1:0] bus_rd_data_i,
  output logic          bus_wr_o,
  output logic [DW-1:0] bus_wr_data_o,
  output logic          bus_wr_bank_o,
  output logic          ovf_o,
  input  logic [AW-1:0] peek_sel_i,
  output logic [DW-1:0] peek_data_o
);
  alu_op_e       op;
  logic [DW-1:0] rf_src, aux, src_data, operand, alu_res, merged, fld_mask;
  logic          carry, rf_we, opposite, bus_we;

  assign op       = alu_op_e'(alu_op_i);
  assign src_data = src_is_bus_i ? bus_rd_data_i : rf_src;
  assign opposite = src_is_bus_i && (src_bank_i != dst_bank_i);
  assign rf_we    = op_valid_i && !dst_is_bus_i;
  assign bus_we   = op_valid_i && dst_is_bus_i;

  fld_regfile #(.DW(DW), .NREGS(NREGS), .AW(AW)) u_rf (
    .clk_i, .rst_ni,
    .we_i(rf_we), .waddr_i(dst_sel_i), .wdata_i(alu_res),
    .raddr_i(src_sel_i), .rdata_o(rf_src), .aux_o(aux),
    .peek_addr_i(peek_sel_i), .peek_data_o(peek_data_o)
  );

  fld_rotmask #(.DW(DW), .SW(SW)) u_rot (
    .data_i(src_data), .rot_i(rot_amt_i), .len_i(fld_len_i),
    .mask_en_i(src_is_bus_i), .data_o(operand)
  );

  fld_alu #(.DW(DW)) u_alu (
    .op_i(op), .a_i(operand), .aux_i(aux), .res_o(alu_res), .carry_o(carry)
  );

  // bus latch background: destination prior contents or same-bank source data
  fld_merge #(.DW(DW), .SW(SW)) u_mrg (
    .res_i(alu_res), .latch_i(bus_rd_data_i), .len_i(fld_len_i), .pos_i(fld_pos_i),
    .opposite_i(opposite), .fld_mask_o(fld_mask), .data_o(merged)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bus_wr_o      <= 1'b0;
      bus_wr_data_o <= '0;
      bus_wr_bank_o <= 1'b0;
      ovf_o         <= 1'b0;
    end else begin
      bus_wr_o <= bus_we;
      if (bus_we) begin
        bus_wr_data_o <= merged;
        bus_wr_bank_o <= dst_bank_i;
      end
      if (op_valid_i && op == ALU_ADD) ovf_o <= carry;
    end
  end

  assert_ovf_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_valid_i && op == ALU_ADD) |=> $stable(ovf_o));

  assert_no_bus_write_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(op_valid_i && dst_is_bus_i) |=> !bus_wr_o);

  assert_keep_outside_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && dst_is_bus_i && !opposite) |=>
      ((bus_wr_data_o ^ $past(bus_rd_data_i)) & ~$past(fld_mask)) == '0);

  assert_opposite_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && dst_is_bus_i && opposite) |=> (bus_wr_data_o & ~$past(fld_mask)) == '0);

  assert_bank_follows_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_valid_i && dst_is_bus_i) |=> bus_wr_o && (bus_wr_bank_o == $past(dst_bank_i)));
endmodule

// File: tb/tb_fld_datapath.sv
module tb_fld_datapath;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic       wr;
    logic [7:0] data;
    logic       bank;
    logic       ovf;
    string      tag;
  } exp_t;

  logic       clk = 0, rst_ni = 0;
  logic       op_valid_i = 0, src_is_bus_i = 0, src_bank_i = 0;
  logic       dst_is_bus_i = 0, dst_bank_i = 0;
  logic [2:0] src_sel_i = 0, dst_sel_i = 0, rot_amt_i = 0, fld_len_i = 0, fld_pos_i = 0;
  logic [2:0] peek_sel_i = 0;
  logic [1:0] alu_op_i = 0;
  logic [7:0] bus_rd_data_i = 0;
  logic       bus_wr_o, bus_wr_bank_o, ovf_o;
  logic [7:0] bus_wr_data_o, peek_data_o;

  int   checks = 0, fails = 0;
  bit   done = 0;
  exp_t q[$];
  logic [7:0] m_regs [8];
  logic       m_ovf = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fld_datapath dut (
    .clk_i(clk), .rst_ni, .op_valid_i, .src_is_bus_i, .src_sel_i, .src_bank_i,
    .dst_is_bus_i, .dst_sel_i, .dst_bank_i, .alu_op_i, .rot_amt_i, .fld_len_i,
    .fld_pos_i, .bus_rd_data_i, .bus_wr_o, .bus_wr_data_o, .bus_wr_bank_o,
    .ovf_o, .peek_sel_i, .peek_data_o
  );

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ror8(logic [7:0] v, int r);
    logic [7:0] o;
    for (int i = 0; i < 8; i++) o[i] = v[(i + r) % 8];
    return o;
  endfunction

  // one driver cycle: drive at negedge, push the expected outcome
  task automatic step(bit v, bit sb, int ss, bit sbk, bit db, int ds, bit dbk,
                      int op, int rot, int len, int pos, logic [7:0] bus, string tag);
    exp_t e;
    logic [7:0] src, opd, res, fm, sh;
    logic [8:0] sum;
    int L;
    @(negedge clk);
    op_valid_i = v; src_is_bus_i = sb; src_sel_i = 3'(ss); src_bank_i = sbk;
    dst_is_bus_i = db; dst_sel_i = 3'(ds); dst_bank_i = dbk; alu_op_i = 2'(op);
    rot_amt_i = 3'(rot); fld_len_i = 3'(len); fld_pos_i = 3'(pos); bus_rd_data_i = bus;
    L = len + 1;
    src = sb ? bus : m_regs[ss];
    opd = ror8(src, rot);
    if (sb) for (int i = L; i < 8; i++) opd[i] = 1'b0;
    sum = {1'b0, opd} + {1'b0, m_regs[0]};
    case (op)
      0: res = opd;
      1: res = sum[7:0];
      2: res = opd & m_regs[0];
      default: res = opd ^ m_regs[0];
    endcase
    e.wr = 0; e.data = 0; e.bank = 0; e.tag = tag;
    if (v) begin
      if (op == 1) m_ovf = sum[8];
      if (!db) m_regs[ds] = res;
      else begin
        e.wr = 1; e.bank = dbk;
        fm = 0; sh = 0;
        if (L == 8) begin fm = 8'hFF; sh = res; end
        else begin
          for (int i = 0; i < 8; i++) if (i >= pos && i < pos + L) fm[i] = 1'b1;
          sh = res << pos;
        end
        if (sb && sbk != dbk) e.data = sh & fm;
        else e.data = (bus & ~fm) | (sh & fm);
      end
    end
    e.ovf = m_ovf;
    q.push_back(e);
  endtask

  task automatic idle(string tag);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 8'h00, tag);
  endtask

  task automatic peek(int a, string tag);
    peek_sel_i = 3'(a);
    #1;
    chk(tag, peek_data_o, m_regs[a]);
  endtask

  // monitor: compare results one step after each driven cycle
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        chk({e.tag, " wr"}, {7'b0, bus_wr_o}, {7'b0, e.wr});
        chk({e.tag, " R5 ovf"}, {7'b0, ovf_o}, {7'b0, e.ovf});
        if (e.wr) begin
          chk({e.tag, " data"}, bus_wr_data_o, e.data);
          chk({e.tag, " bank"}, {7'b0, bus_wr_bank_o}, {7'b0, e.bank});
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) m_regs[i] = 8'h00;
    #(CLK_PERIOD * 3);
    // R1 reset state, R12 peek port
    chk("R1 bus_wr", {7'b0, bus_wr_o}, 8'h00);
    chk("R1 data", bus_wr_data_o, 8'h00);
    chk("R1 ovf", {7'b0, ovf_o}, 8'h00);
    for (int i = 0; i < 8; i++) peek(i, "R1 R12 reg");
    @(negedge clk); rst_ni = 1;

    // loads through full-width bus moves (R3, R6)
    step(1, 1, 0, 0, 0, 1, 0, 0, 0, 7, 0, 8'hB4, "R6 load r1");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, 7, 0, 8'h3C, "R6 load aux");
    idle("R11 idle");
    peek(1, "R6 r1"); peek(0, "R6 aux");

    // R2 register rotate, length ignored
    step(1, 0, 1, 0, 0, 2, 0, 0, 3, 2, 0, 8'h00, "R2 ror3");
    step(1, 0, 1, 0, 0, 5, 0, 0, 7, 0, 0, 8'h00, "R2 ror7");
    idle("R11 idle");
    peek(2, "R2 r2"); peek(5, "R2 r5");

    // R3 bus rotate then mask
    step(1, 1, 0, 0, 0, 3, 0, 0, 2, 2, 0, 8'hE7, "R3 mask3");
    step(1, 1, 0, 0, 0, 6, 0, 0, 5, 4, 0, 8'h9D, "R3 mask5");
    idle("R11 idle");
    peek(3, "R3 r3"); peek(6, "R3 r6");

    // R4 ALU ops, R5 flag
    step(1, 0, 1, 0, 0, 4, 0, 1, 0, 0, 0, 8'h00, "R4 add");
    step(1, 0, 1, 0, 0, 7, 0, 2, 0, 0, 0, 8'h00, "R4 and");
    step(1, 0, 2, 0, 0, 3, 0, 3, 1, 0, 0, 8'h00, "R4 xor");
    step(1, 1, 0, 0, 0, 4, 0, 1, 0, 7, 0, 8'hF0, "R5 add carry");
    step(1, 0, 1, 0, 0, 2, 0, 3, 0, 0, 0, 8'h00, "R5 xor hold");
    idle("R5 idle hold");
    peek(4, "R4 r4"); peek(7, "R4 r7"); peek(3, "R4 r3"); peek(2, "R4 r2");
    step(1, 1, 0, 0, 0, 4, 0, 1, 0, 7, 0, 8'h01, "R5 add clear");

    // R7 register source to bus, merge into prior contents
    step(1, 0, 1, 0, 1, 0, 0, 0, 0, 3, 2, 8'hFF, "R7 merge");
    step(1, 0, 1, 0, 1, 0, 1, 0, 1, 3, 6, 8'h00, "R7 clipped");
    step(1, 0, 2, 0, 1, 0, 1, 3, 0, 0, 0, 8'hAA, "R7 one bit");
    // R8 same bank, R9 opposite bank on identical data
    step(1, 1, 0, 1, 1, 0, 1, 2, 4, 1, 5, 8'h5A, "R8 same bank");
    step(1, 1, 0, 1, 1, 0, 1, 0, 3, 2, 3, 8'hC6, "R8 same bank2");
    step(1, 1, 0, 0, 1, 0, 1, 2, 4, 1, 5, 8'h5A, "R9 opposite");
    step(1, 1, 0, 1, 1, 0, 0, 1, 3, 2, 3, 8'hC6, "R9 opposite2");
    // R10 full width ignores position
    step(1, 0, 1, 0, 1, 0, 0, 3, 2, 7, 5, 8'h0F, "R10 full reg");
    step(1, 1, 0, 0, 1, 0, 0, 1, 1, 7, 6, 8'h81, "R10 full bus");

    // R11 invalid op with register and bus targets
    step(0, 0, 1, 0, 0, 1, 0, 1, 3, 7, 0, 8'hFF, "R11 no reg write");
    step(0, 1, 0, 0, 1, 0, 0, 1, 0, 7, 0, 8'hFF, "R11 no bus write");
    idle("R11 idle");
    peek(1, "R11 r1 kept");
    idle("drain");
    idle("drain");
    @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule